// File: doc/BRIEF.md
# Multi-Channel Debug Break Comparator

This block watches the bus cycles on three address buses (the instruction-fetch bus, the memory-access bus and the internal bus). It raises a break request when a programmed condition matches. Four channels work independently. Each channel holds a compare address, a per-bit address mask and one control word. The control word selects the bus to watch, the cycle type, the direction, the operand size, the bus master, and whether an instruction break is taken before or after the instruction executes.

Software programs the channels through a simple register write port. Each matching bus cycle produces a per-channel match flag and a one-cycle trigger pulse for an external pin. It also produces a break request: a pre-execution pulse, or for post-execution fetch breaks, a pulse that waits for the next instruction-completion strobe. Sticky per-channel flags record which channels have matched until software clears them.

Top module: `brk_unit`

## Requirements
- R1: After a synchronous active-low reset, every compare address, mask, control word, flag, pending break and output is zero, so every channel is disabled.
- R2: A channel's address compares equal when every address bit whose mask bit is 0 equals the compare address bit; a mask bit of 1 makes that bit don't-care.
- R3: Control bits [3:2] pick the bus a channel watches: 00 fetch bus (index 0), 01 memory-access bus (index 1), 10 internal bus (index 2), 11 none. Cycles on other buses never match that channel.
- R4: Control bits [1:0] give the cycle type: 00 disabled, 01 fetch only, 10 data only, 11 either. A fetch cycle (bus_fetch=1) never matches on the internal bus.
- R5: Control bits [5:4] give the direction: 01 reads only (bus_wr=0), 10 writes only (bus_wr=1), 00 or 11 either.
- R6: Control bits [7:6] give the size: 00 any, otherwise the value must equal the cycle's size code (01 byte, 10 word, 11 longword).
- R7: Control bits [9:8] give the master filter: 01 CPU only (bus_dma=0), 10 DMA only (bus_dma=1), 00 or 11 either. The filter is applied only when the internal bus is selected and is ignored on the other two buses.
- R8: ch_match shows the matching channels, and trig pulses high for exactly one cycle; both appear in the clock cycle after the bus cycle.
- R9: brk_pre pulses in the same cycle as ch_match for every data match, and for every fetch match whose control bit [10] (post) is 0.
- R10: A fetch match with control bit [10] set makes a break pending. brk_post pulses one cycle after the first insn_done strobe in a cycle later than the matched fetch cycle, and the pending state then clears.
- R11: A matching channel sets its sticky flag. A write with reg_sel=3 clears every flag whose reg_wdata bit is 1, whatever reg_ch is. A set in the same cycle wins over a clear.
- R12: A write with reg_we=1 stores reg_wdata into the channel chosen by reg_ch: reg_sel 0 writes the compare address, 1 the mask, and 2 the control word (bits [10:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 3 | Per-bus cycle-valid strobe (0 fetch, 1 memory, 2 internal) |
| bus_addr | input | 3x32 | Per-bus cycle address |
| bus_wr | input | 3 | Per-bus direction, 1 = write |
| bus_size | input | 3x2 | Per-bus size code: 01 byte, 10 word, 11 longword |
| bus_fetch | input | 3 | Per-bus cycle kind, 1 = instruction fetch |
| bus_dma | input | 3 | Per-bus master, 1 = DMA controller, 0 = CPU |
| insn_done | input | 1 | Instruction-completion strobe |
| reg_we | input | 1 | Register write enable |
| reg_ch | input | 2 | Channel selected by a write |
| reg_sel | input | 2 | Write target: 0 address, 1 mask, 2 control, 3 flag clear |
| reg_wdata | input | 32 | Write data |
| ch_match | output | 4 | Per-channel match of the previous cycle |
| flags | output | 4 | Sticky per-channel match flags |
| trig | output | 1 | One-cycle trigger pulse on any match |
| brk_pre | output | 1 | Break request issued with the match |
| brk_post | output | 1 | Break request issued after instruction completion |

## Verification
ch_match, trig, brk_pre and the flag set are each due one clock edge after the bus cycle that causes them. A register write takes effect at the edge where it is sampled. brk_post is due one edge after the qualifying insn_done strobe, never in response to a strobe in the cycle of the fetch itself. The bench drives every stimulus on the falling edge. It samples one time unit after the next rising edge, so each check reads exactly the cycle in which its result is due. The post-execution case steps one cycle at a time, to show that the pulse appears neither early nor twice.

// File: rtl/brk_pkg.sv
// Shared types for the debug break comparator.
// Assumes three monitored buses at fixed indices: 0 fetch, 1 memory, 2 internal.
package brk_pkg;
    localparam int NBUS   = 3;
    localparam int BUS_IX = 2;   // internal bus index

    typedef enum logic [1:0] {
        CYC_OFF   = 2'b00,
        CYC_FETCH = 2'b01,
        CYC_DATA  = 2'b10,
        CYC_ANY   = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        BUS_F    = 2'b00,
        BUS_M    = 2'b01,
        BUS_I    = 2'b10,
        BUS_NONE = 2'b11
    } bus_e;

    // Control word, MSB first: post[10] mst[9:8] size[7:6] dir[5:4] bus[3:2] cyc[1:0]
    typedef struct packed {
        logic       post;
        logic [1:0] mst;
        logic [1:0] size;
        logic [1:0] dir;
        bus_e       bus;
        cyc_e       cyc;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/brk_regs.sv
// Per-channel configuration registers and sticky match flags.
// Assumes AW >= CTRL_W and AW >= NCH; a flag set wins over a clear in the same cycle.
module brk_regs
    import brk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [CHW-1:0]          reg_ch,
    input  logic [1:0]              reg_sel,
    input  logic [AW-1:0]           reg_wdata,
    input  logic [NCH-1:0]          hit,
    output logic [NCH-1:0][AW-1:0]  cmp_addr,
    output logic [NCH-1:0][AW-1:0]  cmp_mask,
    output ctrl_t [NCH-1:0]         ctrl,
    output logic [NCH-1:0]          flags
);
    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_CLR  = 2'd3;

    logic clr_wr;
    assign clr_wr = reg_we && (reg_sel == SEL_CLR);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ch_wr;
        assign ch_wr = reg_we && (reg_ch == CHW'(g));

        // Store address, mask and control on a write to this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_addr[g] <= '0;
                cmp_mask[g] <= '0;
                ctrl[g]     <= '0;
            end else if (ch_wr) begin
                case (reg_sel)
                    SEL_ADDR: cmp_addr[g] <= reg_wdata;
                    SEL_MASK: cmp_mask[g] <= reg_wdata;
                    SEL_CTRL: ctrl[g]     <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end

        // Sticky flag: set on a match, cleared by write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[g] <= 1'b0;
            else if (hit[g])                 flags[g] <= 1'b1;
            else if (clr_wr && reg_wdata[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/brk_chan_match.sv
// Combinational condition match for one channel against the selected bus.
// Assumes bus index 2 is the internal bus; fetch conditions never match there.
module brk_chan_match
    import brk_pkg::*;
#(
    parameter int AW = 32
) (
    input  ctrl_t                    ctrl,
    input  logic [AW-1:0]            cmp_addr,
    input  logic [AW-1:0]            cmp_mask,
    input  logic [NBUS-1:0]          bus_vld,
    input  logic [NBUS-1:0][AW-1:0]  bus_addr,
    input  logic [NBUS-1:0]          bus_wr,
    input  logic [NBUS-1:0][1:0]     bus_size,
    input  logic [NBUS-1:0]          bus_fetch,
    input  logic [NBUS-1:0]          bus_dma,
    output logic                     hit,
    output logic                     hit_fetch
);
    logic          vld, wr, fch, dma, on_ibus;
    logic [AW-1:0] addr;
    logic [1:0]    size;
    logic          addr_ok, cyc_ok, dir_ok, size_ok, mst_ok;

    // Pick the attributes of the selected bus; an unused selector gives no cycle.
    always_comb begin
        vld  = 1'b0;
        addr = '0;
        wr   = 1'b0;
        size = '0;
        fch  = 1'b0;
        dma  = 1'b0;
        for (int b = 0; b < NBUS; b++) begin
            if (ctrl.bus == bus_e'(b)) begin
                vld  = bus_vld[b];
                addr = bus_addr[b];
                wr   = bus_wr[b];
                size = bus_size[b];
                fch  = bus_fetch[b];
                dma  = bus_dma[b];
            end
        end
    end

    assign on_ibus = (ctrl.bus == BUS_I);
    assign addr_ok = (((addr ^ cmp_addr) & ~cmp_mask) == '0);

    // Cycle-type check with the fetch restriction on the internal bus.
    always_comb begin
        case (ctrl.cyc)
            CYC_FETCH: cyc_ok = fch && !on_ibus;
            CYC_DATA:  cyc_ok = !fch;
            CYC_ANY:   cyc_ok = fch ? !on_ibus : 1'b1;
            default:   cyc_ok = 1'b0;
        endcase
    end

    // Direction, size and master filters, each with a don't-care code.
    always_comb begin
        case (ctrl.dir)
            2'b01:   dir_ok = !wr;
            2'b10:   dir_ok = wr;
            default: dir_ok = 1'b1;
        endcase
        size_ok = (ctrl.size == 2'b00) || (ctrl.size == size);
        case (ctrl.mst)
            2'b01:   mst_ok = !on_ibus || !dma;
            2'b10:   mst_ok = !on_ibus || dma;
            default: mst_ok = 1'b1;
        endcase
    end

    assign hit       = vld && addr_ok && cyc_ok && dir_ok && size_ok && mst_ok;
    assign hit_fetch = hit && fch;
endmodule

// File: rtl/brk_seq.sv
// Registers match results and sequences pre- and post-execution break requests.
// Assumes a post break waits for an insn_done strobe in a later cycle than its fetch.
module brk_seq #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] hit_fetch,
    input  logic [NCH-1:0] post_sel,
    input  logic           insn_done,
    output logic [NCH-1:0] ch_match,
    output logic           trig,
    output logic           brk_pre,
    output logic           brk_post
);
    logic pend_q, pre_now, post_now;

    assign post_now = |(hit_fetch & post_sel);
    assign pre_now  = |(hit & ~(hit_fetch & post_sel));

    // Register matches, trigger, break pulses and the pending post break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_match <= '0;
            trig     <= 1'b0;
            brk_pre  <= 1'b0;
            brk_post <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            ch_match <= hit;
            trig     <= |hit;
            brk_pre  <= pre_now;
            brk_post <= pend_q && insn_done;
            pend_q   <= post_now || (pend_q && !insn_done);
        end
    end
endmodule

// File: rtl/brk_unit.sv
// Top of the debug break comparator: NCH channels over three monitored buses.
// Assumes bus order fetch, memory, internal and a single write port for setup.
module brk_unit
    import brk_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              bus_vld,
    input  logic [2:0][AW-1:0]      bus_addr,
    input  logic [2:0]              bus_wr,
    input  logic [2:0][1:0]         bus_size,
    input  logic [2:0]              bus_fetch,
    input  logic [2:0]              bus_dma,
    input  logic                    insn_done,
    input  logic                    reg_we,
    input  logic [CHW-1:0]          reg_ch,
    input  logic [1:0]              reg_sel,
    input  logic [AW-1:0]           reg_wdata,
    output logic [NCH-1:0]          ch_match,
    output logic [NCH-1:0]          flags,
    output logic                    trig,
    output logic                    brk_pre,
    output logic                    brk_post
);
    logic [NCH-1:0][AW-1:0] cmp_addr, cmp_mask;
    ctrl_t [NCH-1:0]        ctrl;
    logic [NCH-1:0]         hit, hit_fetch, post_sel;

    brk_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ch(reg_ch),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .hit(hit),
        .cmp_addr(cmp_addr), .cmp_mask(cmp_mask), .ctrl(ctrl), .flags(flags)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_match
        brk_chan_match #(.AW(AW)) u_match (
            .ctrl(ctrl[g]), .cmp_addr(cmp_addr[g]), .cmp_mask(cmp_mask[g]),
            .bus_vld(bus_vld), .bus_addr(bus_addr), .bus_wr(bus_wr),
            .bus_size(bus_size), .bus_fetch(bus_fetch), .bus_dma(bus_dma),
            .hit(hit[g]), .hit_fetch(hit_fetch[g])
        );
        assign post_sel[g] = ctrl[g].post;
    end

    brk_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_fetch(hit_fetch),
        .post_sel(post_sel), .insn_done(insn_done), .ch_match(ch_match),
        .trig(trig), .brk_pre(brk_pre), .brk_post(brk_post)
    );
endmodule

// File: rtl/brk_unit_chk.sv
// Checker for brk_unit, attached with bind; observes ports only.
module brk_unit_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [1:0]     reg_sel,
    input logic           insn_done,
    input logic [NCH-1:0] ch_match,
    input logic [NCH-1:0] flags,
    input logic           trig,
    input logic           brk_pre,
    input logic           brk_post
);
    // R1: leaving reset, nothing has matched and no flag is set
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ch_match == '0 && flags == '0 && !trig));

    // R8: the trigger pulse coincides with a channel match
    p_trig_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig == (ch_match != '0));

    // R9: a pre break needs a match in the same cycle
    p_pre_with_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pre |-> (ch_match != '0));

    // R10: a post break follows an insn_done strobe
    p_post_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_post |-> $past(insn_done));

    // R11: a matched channel shows its flag
    p_match_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ch_match) == ch_match));

    // R11: flags only fall after a clear write
    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we && reg_sel == 2'd3) |-> ((flags & $past(flags)) == $past(flags)));
endmodule

bind brk_unit brk_unit_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .insn_done(insn_done), .ch_match(ch_match), .flags(flags),
    .trig(trig), .brk_pre(brk_pre), .brk_post(brk_post)
);

// File: tb/tb_brk_unit.sv
module tb_brk_unit;
    logic             clk = 1'b0;
    logic             rst_n;
    logic [2:0]       bus_vld, bus_wr, bus_fetch, bus_dma;
    logic [2:0][31:0] bus_addr;
    logic [2:0][1:0]  bus_size;
    logic             insn_done, reg_we;
    logic [1:0]       reg_ch, reg_sel;
    logic [31:0]      reg_wdata;
    logic [3:0]       ch_match, flags;
    logic             trig, brk_pre, brk_post;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    brk_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_size(bus_size), .bus_fetch(bus_fetch),
        .bus_dma(bus_dma), .insn_done(insn_done), .reg_we(reg_we),
        .reg_ch(reg_ch), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ch_match(ch_match), .flags(flags), .trig(trig),
        .brk_pre(brk_pre), .brk_post(brk_post)
    );

    typedef struct packed {
        logic [1:0]  bus;
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  size;
        logic        fch;
        logic        dma;
        logic [3:0]  m;
        logic        pre;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 32'h1000_0034, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0001, 1'b1, 4'd2},  // R2 masked low byte
        '{2'd0, 32'h1000_0134, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2 unmasked bit differs
        '{2'd1, 32'h2000_0040, 1'b1, 2'd3, 1'b0, 1'b0, 4'b0010, 1'b1, 4'd5},  // R5 write long hits
        '{2'd1, 32'h2000_0040, 1'b0, 2'd3, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd5},  // R5 read rejected
        '{2'd1, 32'h2000_0040, 1'b1, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd6},  // R6 word rejected
        '{2'd1, 32'h2000_0040, 1'b1, 2'd3, 1'b0, 1'b1, 4'b0010, 1'b1, 4'd7},  // R7 master ignored off internal bus
        '{2'd2, 32'h3000_0007, 1'b0, 2'd1, 1'b0, 1'b1, 4'b0100, 1'b1, 4'd7},  // R7 DMA on internal bus
        '{2'd2, 32'h3000_0007, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd7},  // R7 CPU rejected
        '{2'd1, 32'h3000_0007, 1'b0, 2'd1, 1'b0, 1'b1, 4'b0000, 1'b0, 4'd3},  // R3 wrong bus
        '{2'd0, 32'h2000_0040, 1'b1, 2'd3, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd3},  // R3 wrong bus
        '{2'd1, 32'h1000_0034, 1'b0, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0, 4'd3},  // R3 fetch on memory bus
        '{2'd0, 32'h1000_0034, 1'b0, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b0, 4'd4}   // R4 data on fetch-only channel
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        bus_vld = '0; bus_addr = '0; bus_wr = '0; bus_size = '0;
        bus_fetch = '0; bus_dma = '0; insn_done = 1'b0;
        reg_we = 1'b0; reg_ch = '0; reg_sel = '0; reg_wdata = '0;
    endtask

    task automatic set_bus(input int b, input logic [31:0] a, input logic w,
                           input logic [1:0] s, input logic f, input logic d);
        bus_vld[b] = 1'b1; bus_addr[b] = a; bus_wr[b] = w;
        bus_size[b] = s; bus_fetch[b] = f; bus_dma[b] = d;
    endtask

    task automatic set_wr(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] d);
        reg_we = 1'b1; reg_ch = ch; reg_sel = sel; reg_wdata = d;
    endtask

    task automatic begin_cyc();
        @(negedge clk);
        clear_in();
    endtask

    task automatic end_cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [1:0] ch, input logic [1:0] sel, input logic [31:0] d);
        begin_cyc(); set_wr(ch, sel, d); end_cyc();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: outputs clear after reset
        chk("R1 match", {28'd0, ch_match}, 32'd0);
        chk("R1 flags", {28'd0, flags}, 32'd0);
        chk("R1 pulses", {29'd0, trig, brk_pre, brk_post}, 32'd0);
        // R1: reset controls disable all channels (address 0 with zero compare)
        begin_cyc(); set_bus(0, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0); end_cyc();
        chk("R1 disabled", {28'd0, ch_match}, 32'd0);

        // R12: program the four channels
        write_reg(2'd0, 2'd0, 32'h1000_0000); write_reg(2'd0, 2'd1, 32'h0000_00FF);
        write_reg(2'd0, 2'd2, 32'h001);
        write_reg(2'd1, 2'd0, 32'h2000_0040); write_reg(2'd1, 2'd2, 32'h2E6);
        write_reg(2'd2, 2'd0, 32'h3000_0000); write_reg(2'd2, 2'd1, 32'h0000_000F);
        write_reg(2'd2, 2'd2, 32'h25A);
        write_reg(2'd3, 2'd0, 32'h4000_0010); write_reg(2'd3, 2'd2, 32'h401);

        // Table walk: one bus cycle per vector, checked at the following edge (R8, R9)
        for (int i = 0; i < NV; i++) begin
            begin_cyc();
            set_bus(int'(TBL[i].bus), TBL[i].addr, TBL[i].wr, TBL[i].size, TBL[i].fch, TBL[i].dma);
            end_cyc();
            chk($sformatf("vector %0d R%0d match", i, TBL[i].req), {28'd0, ch_match}, {28'd0, TBL[i].m});
            chk($sformatf("vector %0d R8 trig", i), {31'd0, trig}, {31'd0, (TBL[i].m != 4'd0)});
            chk($sformatf("vector %0d R9 pre", i), {31'd0, brk_pre}, {31'd0, TBL[i].pre});
            chk($sformatf("vector %0d R10 post", i), {31'd0, brk_post}, 32'd0);
        end

        // R11: sticky flags after the table
        chk("R11 flags sticky", {28'd0, flags}, 32'h7);
        // R11: clear bits 0 and 1 while channel 1 matches: set wins on bit 1
        begin_cyc();
        set_wr(2'd3, 2'd3, 32'h3);
        set_bus(1, 32'h2000_0040, 1'b1, 2'd3, 1'b0, 1'b0);
        end_cyc();
        chk("R11 set beats clear", {28'd0, flags}, 32'h6);

        // R8: two buses match in one cycle, trigger lasts one cycle
        begin_cyc();
        set_bus(0, 32'h1000_00AA, 1'b0, 2'd2, 1'b1, 1'b0);
        set_bus(1, 32'h2000_0040, 1'b1, 2'd3, 1'b0, 1'b0);
        end_cyc();
        chk("R8 two channels", {28'd0, ch_match}, 32'h3);
        chk("R8 trig high", {31'd0, trig}, 32'd1);
        begin_cyc(); end_cyc();
        chk("R8 trig one cycle", {31'd0, trig}, 32'd0);

        // R10: post fetch break with a same-cycle strobe that must not count
        begin_cyc();
        set_bus(0, 32'h4000_0010, 1'b0, 2'd2, 1'b1, 1'b0);
        insn_done = 1'b1;
        end_cyc();
        chk("R10 post match", {28'd0, ch_match}, 32'h8);
        chk("R9 no pre for post fetch", {31'd0, brk_pre}, 32'd0);
        chk("R10 not yet", {31'd0, brk_post}, 32'd0);
        begin_cyc(); end_cyc();
        chk("R10 waits for strobe", {31'd0, brk_post}, 32'd0);
        begin_cyc(); insn_done = 1'b1; end_cyc();
        chk("R10 issued", {31'd0, brk_post}, 32'd1);
        begin_cyc(); insn_done = 1'b1; end_cyc();
        chk("R10 single pulse", {31'd0, brk_post}, 32'd0);

        // R4: cycle type 00 disables channel 0
        write_reg(2'd0, 2'd2, 32'h000);
        begin_cyc(); set_bus(0, 32'h1000_0034, 1'b0, 2'd2, 1'b1, 1'b0); end_cyc();
        chk("R4 disabled", {28'd0, ch_match}, 32'd0);
        // R4: fetch-only on the internal bus never matches
        write_reg(2'd0, 2'd2, 32'h009);
        begin_cyc(); set_bus(2, 32'h1000_0034, 1'b0, 2'd2, 1'b1, 1'b0); end_cyc();
        chk("R4 fetch on internal", {28'd0, ch_match}, 32'd0);
        // R4: either-type on the internal bus takes a data cycle
        write_reg(2'd0, 2'd2, 32'h00B);
        begin_cyc(); set_bus(2, 32'h1000_0034, 1'b0, 2'd2, 1'b0, 1'b0); end_cyc();
        chk("R4 any data", {28'd0, ch_match}, 32'h1);
        // R12: new compare address takes effect
        write_reg(2'd0, 2'd0, 32'h5000_0000);
        begin_cyc(); set_bus(2, 32'h5000_00C3, 1'b1, 2'd1, 1'b0, 1'b1); end_cyc();
        chk("R12 new address", {28'd0, ch_match}, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule